// File: doc/BRIEF.md
# Vector Predicate Register File with Element Write-Merge

This block holds one thread's set of eight 16-bit predicate registers and the lane logic that uses them when a 512-bit vector result is written back. A computed vector is merged with the previous destination vector under a selected predicate. Each lane whose predicate bit is set takes the new value. Each lane whose bit is clear keeps the previous value unchanged. Lanes can be sixteen 32-bit elements, or eight 64-bit elements that use only the low eight predicate bits. Selector 0 in the write-predicate role is not a register reference: it stands for an all-ones predicate, so an unpredicated operation updates every lane.

A blend mode uses the same lane selector to choose between two source vectors. In this mode selector 0 does refer to the stored register 0. The block also runs the three bitwise predicate operations (AND, OR and XOR) from two registers into a third. A write-back port stores per-element compare or carry-out bits into any register, including register 0. A general read port and a carry-in port show register contents to the arithmetic units that surround the block. Those arithmetic units and memory access are not part of this block.

Top module: `vpred_merge_unit`

## Requirements
- R1: After reset every predicate register reads 0x0000 on the read port and on the carry-in port.
- R2: With blend off and write-predicate selector 0, the merged output equals the new vector in all lanes, whatever register 0 holds.
- R3: In 32-bit mode (elem64=0) with selector 1 to 7, lane i (bits 32i+31 to 32i, i = 0 to 15) of the merged output equals the new vector's lane when bit i of the selected register is 1. When the bit is 0 it equals the old vector's lane, and is never cleared.
- R4: In 64-bit mode (elem64=1), element k (bits 64k+63 to 64k, k = 0 to 7) follows bit k of the effective predicate. Predicate bits 15 to 8 have no effect.
- R5: In blend mode (blend_en=1), bit 1 selects the new_vec element and bit 0 selects the old_vec element. Every selector, 0 included, reads the stored register.
- R6: A predicate operation with op_valid=1 writes into register op_dst the result of the two source registers combined per op_code: 0 = AND, 1 = OR, 2 = XOR. The result can be read after the next clock edge. Code 3 writes nothing.
- R7: flag_we=1 stores flag_bits into register flag_dst at the next edge, register 0 included. When a valid predicate operation targets the same register in the same cycle, the operation's result is stored.
- R8: Reads are combinational. A register being written in the current cycle still reads its old value until the clock edge.
- R9: cin_bits always shows the contents of the register picked by cin_sel, so stored carry-out bits can be supplied as carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| rd_sel | input | 3 | General read register select |
| rd_bits | output | 16 | General read data |
| cin_sel | input | 3 | Carry-in register select |
| cin_bits | output | 16 | Carry-in bits |
| flag_we | input | 1 | Compare/carry bit write enable |
| flag_dst | input | 3 | Compare/carry bit destination register |
| flag_bits | input | 16 | Per-element compare or carry-out bits |
| op_valid | input | 1 | Predicate Boolean operation request |
| op_code | input | 2 | 0 AND, 1 OR, 2 XOR, 3 no operation |
| op_src_a | input | 3 | First source register |
| op_src_b | input | 3 | Second source register |
| op_dst | input | 3 | Destination register |
| wm_sel | input | 3 | Write-predicate / blend selector |
| elem64 | input | 1 | 1 = eight 64-bit elements, 0 = sixteen 32-bit elements |
| blend_en | input | 1 | 1 = blend two sources, 0 = merge into old destination |
| old_vec | input | 512 | Previous destination (merge) or first source (blend) |
| new_vec | input | 512 | Computed result (merge) or second source (blend) |
| merged_vec | output | 512 | Lane-merged vector |

## Verification
The merge is driven with old and new vectors that differ in every lane and carry the lane number, so a lane taken from the wrong side or from a wrong lane index shows up at once. The predicates used are all zeros, all ones, and alternating and irregular patterns. The irregular pattern separates 32-bit from 64-bit lane mapping. A pattern with only the high byte set shows whether 64-bit mode ignores bits 15 to 8. Register 0 is loaded with zero and then used under selector 0 in merge and in blend mode, which tells the implicit all-ones predicate from a real register read. The Boolean operations use operand pairs whose AND, OR and XOR all differ, and the reserved code is applied to check that it writes nothing.

// File: rtl/vpred_pkg.sv
package vpred_pkg;
   localparam int unsigned DEF_PRED_CNT = 8;
   localparam int unsigned DEF_PRED_W   = 16;
   localparam int unsigned DEF_VEC_W    = 512;

   typedef enum logic [1:0] {
      POP_AND  = 2'd0,
      POP_OR   = 2'd1,
      POP_XOR  = 2'd2,
      POP_NONE = 2'd3
   } pop_e;

   // read port indices into the register file
   localparam int unsigned RP_USER  = 0;
   localparam int unsigned RP_CARRY = 1;
   localparam int unsigned RP_WMASK = 2;
   localparam int unsigned RP_OPA   = 3;
   localparam int unsigned RP_OPB   = 4;
   localparam int unsigned RP_COUNT = 5;
endpackage

// File: rtl/vpred_regfile.sv
module vpred_regfile #(
   parameter int unsigned N   = 8,
   parameter int unsigned W   = 16,
   parameter int unsigned NRD = 5,
   localparam int unsigned AW = $clog2(N)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wa_en,
   input  logic [AW-1:0]            wa_addr,
   input  logic [W-1:0]             wa_data,
   input  logic                     wb_en,
   input  logic [AW-1:0]            wb_addr,
   input  logic [W-1:0]             wb_data,
   input  logic [NRD-1:0][AW-1:0]   rd_addr,
   output logic [NRD-1:0][W-1:0]    rd_data
);
   logic [W-1:0] regs [N];

   if (N != (1 << AW)) begin : g_bad_depth
      $error("vpred_regfile: N must be a power of two");
   end

   for (genvar r = 0; r < N; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[r] <= '0;
         else if (wa_en && wa_addr == AW'(r))
            regs[r] <= wa_data;       // port A has priority
         else if (wb_en && wb_addr == AW'(r))
            regs[r] <= wb_data;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = regs[rd_addr[p]];
   end

   // R6: a Boolean result lands in its destination at the next edge
   a_r6_op_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wa_en |=> regs[$past(wa_addr)] == $past(wa_data));

   // R7: flag write lands unless the op port claimed the same register
   a_r7_flag_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !(wa_en && wa_addr == wb_addr)) |=> regs[$past(wb_addr)] == $past(wb_data));

   // R8: a register not written keeps its value
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wa_en && !wb_en) |=> regs[$past(rd_addr[0])] == $past(rd_data[0]));
endmodule

// File: rtl/vpred_logic_op.sv
module vpred_logic_op
   import vpred_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic [1:0]   code,
   input  logic [W-1:0] src_a,
   input  logic [W-1:0] src_b,
   output logic         wr_en,
   output logic [W-1:0] result
);
   pop_e op;
   assign op = pop_e'(code);

   always_comb begin
      wr_en  = 1'b1;
      result = '0;
      unique case (op)
         POP_AND:  result = src_a & src_b;
         POP_OR:   result = src_a | src_b;
         POP_XOR:  result = src_a ^ src_b;
         default:  wr_en  = 1'b0;
      endcase
   end

   // R6: AND never sets a bit absent from either source; OR covers both
   always_comb begin
      if (op == POP_AND)
         a_r6_and_subset: assert ((result & ~src_a) == '0 && (result & ~src_b) == '0);
      if (op == POP_OR)
         a_r6_or_cover: assert ((src_a & ~result) == '0 && (src_b & ~result) == '0);
   end
endmodule

// File: rtl/vpred_mask_select.sv
module vpred_mask_select #(
   parameter int unsigned W  = 16,
   parameter int unsigned AW = 3
) (
   input  logic [AW-1:0] sel,
   input  logic          blend,
   input  logic [W-1:0]  stored,
   output logic [W-1:0]  eff_mask
);
   logic implicit_ones;
   assign implicit_ones = !blend && (sel == '0);
   assign eff_mask      = implicit_ones ? {W{1'b1}} : stored;
endmodule

// File: rtl/vpred_lane_merge.sv
module vpred_lane_merge #(
   parameter int unsigned VEC_W  = 512,
   parameter int unsigned PRED_W = 16,
   localparam int unsigned LANE_W = VEC_W / PRED_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PRED_W-1:0] mask,
   input  logic              elem64,
   input  logic [VEC_W-1:0]  old_vec,
   input  logic [VEC_W-1:0]  new_vec,
   output logic [VEC_W-1:0]  out_vec
);
   if (VEC_W != LANE_W * PRED_W) begin : g_bad_width
      $error("vpred_lane_merge: VEC_W must be a multiple of PRED_W");
   end
   if (PRED_W % 2 != 0) begin : g_bad_pairs
      $error("vpred_lane_merge: PRED_W must be even for wide elements");
   end

   logic [PRED_W-1:0] lane_take;

   for (genvar i = 0; i < PRED_W; i++) begin : g_lane
      assign lane_take[i] = elem64 ? mask[i/2] : mask[i];
      assign out_vec[i*LANE_W +: LANE_W] =
         lane_take[i] ? new_vec[i*LANE_W +: LANE_W] : old_vec[i*LANE_W +: LANE_W];

      // R3: a lane whose 32-bit predicate bit is clear keeps the old value
      a_r3_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!elem64 && !mask[i]) |-> out_vec[i*LANE_W +: LANE_W] == old_vec[i*LANE_W +: LANE_W]);
      // R4: in wide mode both halves of an element follow the same bit
      a_r4_pair_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (elem64 && mask[i/2]) |-> out_vec[i*LANE_W +: LANE_W] == new_vec[i*LANE_W +: LANE_W]);
   end
endmodule

// File: rtl/vpred_merge_unit.sv
module vpred_merge_unit
   import vpred_pkg::*;
#(
   parameter int unsigned PRED_CNT = DEF_PRED_CNT,
   parameter int unsigned PRED_W   = DEF_PRED_W,
   parameter int unsigned VEC_W    = DEF_VEC_W,
   localparam int unsigned AW      = $clog2(PRED_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_sel,
   output logic [PRED_W-1:0] rd_bits,
   input  logic [AW-1:0]     cin_sel,
   output logic [PRED_W-1:0] cin_bits,
   input  logic              flag_we,
   input  logic [AW-1:0]     flag_dst,
   input  logic [PRED_W-1:0] flag_bits,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic [AW-1:0]     op_src_a,
   input  logic [AW-1:0]     op_src_b,
   input  logic [AW-1:0]     op_dst,
   input  logic [AW-1:0]     wm_sel,
   input  logic              elem64,
   input  logic              blend_en,
   input  logic [VEC_W-1:0]  old_vec,
   input  logic [VEC_W-1:0]  new_vec,
   output logic [VEC_W-1:0]  merged_vec
);
   logic [RP_COUNT-1:0][AW-1:0]     rp_addr;
   logic [RP_COUNT-1:0][PRED_W-1:0] rp_data;
   logic                            op_we;
   logic [PRED_W-1:0]               op_result;
   logic [PRED_W-1:0]               eff_mask;

   assign rp_addr[RP_USER]  = rd_sel;
   assign rp_addr[RP_CARRY] = cin_sel;
   assign rp_addr[RP_WMASK] = wm_sel;
   assign rp_addr[RP_OPA]   = op_src_a;
   assign rp_addr[RP_OPB]   = op_src_b;

   vpred_regfile #(.N(PRED_CNT), .W(PRED_W), .NRD(RP_COUNT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (op_valid && op_we),
      .wa_addr (op_dst),
      .wa_data (op_result),
      .wb_en   (flag_we),
      .wb_addr (flag_dst),
      .wb_data (flag_bits),
      .rd_addr (rp_addr),
      .rd_data (rp_data)
   );

   vpred_logic_op #(.W(PRED_W)) u_bool (
      .code   (op_code),
      .src_a  (rp_data[RP_OPA]),
      .src_b  (rp_data[RP_OPB]),
      .wr_en  (op_we),
      .result (op_result)
   );

   vpred_mask_select #(.W(PRED_W), .AW(AW)) u_sel (
      .sel      (wm_sel),
      .blend    (blend_en),
      .stored   (rp_data[RP_WMASK]),
      .eff_mask (eff_mask)
   );

   vpred_lane_merge #(.VEC_W(VEC_W), .PRED_W(PRED_W)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask    (eff_mask),
      .elem64  (elem64),
      .old_vec (old_vec),
      .new_vec (new_vec),
      .out_vec (merged_vec)
   );

   assign rd_bits  = rp_data[RP_USER];
   assign cin_bits = rp_data[RP_CARRY];

   // R2: selector 0 outside blend passes the whole new vector
   a_r2_sel0_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!blend_en && wm_sel == '0) |-> merged_vec == new_vec);

   // R9: carry port and general port agree when they name the same register
   a_r9_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (cin_sel == rd_sel) |-> cin_bits == rd_bits);
endmodule

// File: tb/vpred_merge_unit_bench.sv
module vpred_merge_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int VW = 512;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [2:0]     rd_sel = '0, cin_sel = '0, flag_dst = '0;
   logic [2:0]     op_src_a = '0, op_src_b = '0, op_dst = '0, wm_sel = '0;
   logic [15:0]    rd_bits, cin_bits, flag_bits = '0;
   logic           flag_we = 1'b0, op_valid = 1'b0, elem64 = 1'b0, blend_en = 1'b0;
   logic [1:0]     op_code = '0;
   logic [VW-1:0]  old_vec, new_vec, merged_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] model [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   vpred_merge_unit u_vpred_merge_unit (
      .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_bits(rd_bits),
      .cin_sel(cin_sel), .cin_bits(cin_bits), .flag_we(flag_we),
      .flag_dst(flag_dst), .flag_bits(flag_bits), .op_valid(op_valid),
      .op_code(op_code), .op_src_a(op_src_a), .op_src_b(op_src_b),
      .op_dst(op_dst), .wm_sel(wm_sel), .elem64(elem64), .blend_en(blend_en),
      .old_vec(old_vec), .new_vec(new_vec), .merged_vec(merged_vec)
   );

   initial begin
      for (int i = 0; i < 16; i++) begin
         old_vec[i*32 +: 32] = 32'hA0A0_0000 | 32'(i);
         new_vec[i*32 +: 32] = 32'h0B0B_0000 | (32'(i) << 8);
      end
   end

   task automatic chk16(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk512(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] exp_merge(logic [15:0] m, bit e64);
      logic [VW-1:0] r;
      for (int i = 0; i < 16; i++) begin
         bit take = e64 ? m[i/2] : m[i];
         r[i*32 +: 32] = take ? new_vec[i*32 +: 32] : old_vec[i*32 +: 32];
      end
      return r;
   endfunction

   task automatic put_flag(logic [2:0] dst, logic [15:0] bits);
      @(negedge clk);
      flag_we = 1'b1; flag_dst = dst; flag_bits = bits;
      @(negedge clk);
      flag_we = 1'b0;
      model[dst] = bits;
   endtask

   task automatic run_op(logic [1:0] code, logic [2:0] a, logic [2:0] b, logic [2:0] d);
      @(negedge clk);
      op_valid = 1'b1; op_code = code; op_src_a = a; op_src_b = b; op_dst = d;
      @(negedge clk);
      op_valid = 1'b0;
      case (code)
         2'd0: model[d] = model[a] & model[b];
         2'd1: model[d] = model[a] | model[b];
         2'd2: model[d] = model[a] ^ model[b];
         default: ;
      endcase
   endtask

   task automatic check_reg(string tag, logic [2:0] idx);
      rd_sel = idx; #1;
      chk16(tag, rd_bits, model[idx]);
   endtask

   task automatic check_merge(string tag, logic [2:0] sel, bit e64, bit bl);
      logic [15:0] m;
      wm_sel = sel; elem64 = e64; blend_en = bl; #1;
      m = (!bl && sel == 3'd0) ? 16'hFFFF : model[sel];
      chk512(tag, merged_vec, exp_merge(m, e64));
   endtask

   task automatic t_reset;
      for (int r = 0; r < 8; r++) model[r] = 16'h0000;
      for (int r = 0; r < 8; r++) begin
         rd_sel = 3'(r); cin_sel = 3'(r); #1;
         chk16("R1 reset read", rd_bits, 16'h0000);
         chk16("R1 reset carry port", cin_bits, 16'h0000);
      end
   endtask

   task automatic t_flag_write;
      put_flag(3'd0, 16'h1234);
      check_reg("R7 flag write to reg 0", 3'd0);
      put_flag(3'd1, 16'hA5C3);
      put_flag(3'd2, 16'h0F0F);
      put_flag(3'd3, 16'h3C3C);
      put_flag(3'd4, 16'hFF00);
      for (int r = 1; r < 5; r++) check_reg("R7 flag write", 3'(r));
   endtask

   task automatic t_bool_ops;
      run_op(2'd0, 3'd2, 3'd3, 3'd5);
      check_reg("R6 AND", 3'd5);
      chk16("R6 AND value", rd_bits, 16'h0C0C);
      run_op(2'd1, 3'd2, 3'd3, 3'd6);
      check_reg("R6 OR", 3'd6);
      chk16("R6 OR value", rd_bits, 16'h3F3F);
      run_op(2'd2, 3'd2, 3'd3, 3'd7);
      check_reg("R6 XOR", 3'd7);
      chk16("R6 XOR value", rd_bits, 16'h3333);
      run_op(2'd3, 3'd2, 3'd3, 3'd7);
      check_reg("R6 reserved code keeps dst", 3'd7);
   endtask

   task automatic t_conflict;
      @(negedge clk);
      op_valid = 1'b1; op_code = 2'd2; op_src_a = 3'd1; op_src_b = 3'd4; op_dst = 3'd6;
      flag_we = 1'b1; flag_dst = 3'd6; flag_bits = 16'hDEAD;
      @(negedge clk);
      op_valid = 1'b0; flag_we = 1'b0;
      model[6] = model[1] ^ model[4];
      check_reg("R7 op wins same-register conflict", 3'd6);
   endtask

   task automatic t_read_old;
      @(negedge clk);
      flag_we = 1'b1; flag_dst = 3'd3; flag_bits = 16'h8001;
      rd_sel = 3'd3; #1;
      chk16("R8 old value before edge", rd_bits, model[3]);
      @(negedge clk);
      flag_we = 1'b0;
      model[3] = 16'h8001;
      check_reg("R8 new value after edge", 3'd3);
   endtask

   task automatic t_merge32;
      put_flag(3'd5, 16'h0000);
      check_merge("R3 all-zero predicate keeps old", 3'd5, 1'b0, 1'b0);
      put_flag(3'd5, 16'hFFFF);
      check_merge("R3 all-ones predicate", 3'd5, 1'b0, 1'b0);
      check_merge("R3 irregular predicate", 3'd1, 1'b0, 1'b0);
      put_flag(3'd5, 16'h5555);
      check_merge("R3 alternating predicate", 3'd5, 1'b0, 1'b0);
   endtask

   task automatic t_sel0;
      put_flag(3'd0, 16'h0000);
      check_merge("R2 selector 0 all ones 32-bit", 3'd0, 1'b0, 1'b0);
      check_merge("R2 selector 0 all ones 64-bit", 3'd0, 1'b1, 1'b0);
      chk512("R2 selector 0 equals new", merged_vec, new_vec);
   endtask

   task automatic t_merge64;
      check_merge("R4 high byte ignored", 3'd4, 1'b1, 1'b0);
      chk512("R4 high byte gives old", merged_vec, old_vec);
      check_merge("R4 irregular wide", 3'd1, 1'b1, 1'b0);
      put_flag(3'd5, 16'h00A5);
      check_merge("R4 low byte wide", 3'd5, 1'b1, 1'b0);
   endtask

   task automatic t_blend;
      check_merge("R5 blend selector 0 uses stored reg", 3'd0, 1'b0, 1'b1);
      chk512("R5 blend zero reg picks first source", merged_vec, old_vec);
      check_merge("R5 blend irregular", 3'd1, 1'b0, 1'b1);
      check_merge("R5 blend wide", 3'd5, 1'b1, 1'b1);
   endtask

   task automatic t_carry;
      put_flag(3'd2, 16'h6B1D);
      cin_sel = 3'd2; #1;
      chk16("R9 carry-out returned as carry-in", cin_bits, 16'h6B1D);
      cin_sel = 3'd7; #1;
      chk16("R9 carry port other register", cin_bits, model[7]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_flag_write;
      t_bool_ops;
      t_conflict;
      t_read_old;
      t_merge32;
      t_sel0;
      t_merge64;
      t_blend;
      t_carry;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
      $finish;
   end
endmodule